// File: doc/BRIEF.md
# Ramped Volume and Mute Controller

This block scales a multichannel stream of signed audio samples by a per-channel attenuation. Each channel has a volume register, which holds the requested attenuation in 0.125 dB units, and a mute bit. The attenuation that is actually applied never jumps. It moves one code (0.125 dB) at a time toward its target. The target is the volume setting, or the 127 dB floor while the channel is muted. A 2-bit rate select sets how many sample periods pass between steps, and all channels share that step timing.

Each applied attenuation code is turned into a linear gain by a table lookup: a 48-entry mantissa table covers one 6 dB segment, and a right shift selects the segment. A signed multiplier then scales the sample by that gain. After reset every channel sits at the floor, so the output fades in to the programmed volumes. Detecting zero crossings and giving software access to the registers are left to neighbouring blocks.

Top module: `soft_vol_ctrl`

## Requirements
- R1: During and after reset, out_valid is 0 and out_data is 0, and every channel starts at the floor code 1016. The first sample after reset therefore leaves as 0.
- R2: out_valid is high exactly one cycle after each in_valid pulse. Channel n occupies bits [n*DATA_W +: DATA_W] of in_data and out_data, in two's complement. The output of each lane is floor(s*g/32768), where g is the gain of the channel's attenuation code as it stood before that sample's step.
- R3: Code 0 has gain exactly 32768, so the sample passes unchanged. Codes of 1016 and above have gain exactly 0. For any other code c, the gain lies within 1 of floor(32768*10^(-(c mod 48)/160)) shifted right by floor(c/48).
- R4: Each step moves the applied code by exactly one toward its target. Once the code equals the target it stays there.
- R5: rate_sel values 0, 1, 2 and 3 give a step on every 1st, 2nd, 4th and 8th in_valid pulse. A single sample counter shared by all channels sets this timing, and it starts from zero at reset.
- R6: While a channel's mute bit is 1, its target is code 1016, whatever its volume setting.
- R7: When a channel's mute bit returns to 0, its target is again that channel's volume code.
- R8: Volume codes above 1016 act as 1016. Channel n's volume lies in bits [n*10 +: 10] of vol_att, and bit n of mute belongs to channel n.
- R9: A target that changes in the middle of a ramp takes effect on the next step, starting from the code reached so far.
- R10: A channel's volume and mute bit affect only that channel's output.
- R11: On cycles without in_valid, out_valid is 0, out_data holds its last value and in_data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | One-cycle strobe marking a sample frame for all channels |
| in_data | input | NUM_CH*DATA_W | Signed sample per channel |
| vol_att | input | NUM_CH*10 | Target attenuation per channel in 0.125 dB units |
| mute | input | NUM_CH | Mute request per channel |
| rate_sel | input | 2 | Step rate: one step per 1, 2, 4 or 8 samples |
| out_valid | output | 1 | Strobe for the scaled frame |
| out_data | output | NUM_CH*DATA_W | Attenuated sample per channel |

## Verification
The assertions assume that in_valid never stays high on two consecutive cycles, which gives the registered gain one idle cycle to follow each step. The muted-output and unity-gain checks depend on that gap. Every frame the stimulus sends is one high cycle followed by at least two low cycles, and vol_att, mute and rate_sel change only in those idle cycles. The bench keeps its own model of every channel's code and of the shared sample counter. It sweeps the full code range at several rates and with mutes and target changes in mid-ramp, and it scales varied positive, negative and full-scale samples.

// File: rtl/svc_pkg.sv
package svc_pkg;

  localparam int ATT_W     = 10;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 15;
  localparam int SEG       = 48;
  localparam int RATE_W    = 2;

  localparam logic [ATT_W-1:0]  ATT_FLOOR  = ATT_W'(1016);
  localparam logic [ATT_W-1:0]  SEG_C      = ATT_W'(SEG);
  localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1 << GAIN_FRAC);

  // ratio of one 0.125 dB step, scaled by 2^32
  localparam longint unsigned STEP_K = 64'd4233600374;

  typedef enum logic [RATE_W-1:0] {
    RATE_EVERY_1 = 2'd0,
    RATE_EVERY_2 = 2'd1,
    RATE_EVERY_4 = 2'd2,
    RATE_EVERY_8 = 2'd3
  } rate_sel_e;

  // mantissa table for one 6 dB segment, built with 30 fractional bits
  function automatic logic [SEG*GAIN_W-1:0] build_mant();
    logic [SEG*GAIN_W-1:0] tbl;
    longint unsigned m;
    tbl = '0;
    m   = 64'd1 << 30;
    for (int i = 0; i < SEG; i++) begin
      tbl[i*GAIN_W +: GAIN_W] = GAIN_W'(m >> (30 - GAIN_FRAC));
      m = (m * STEP_K) >> 32;
    end
    return tbl;
  endfunction

  localparam logic [SEG*GAIN_W-1:0] MANT_TBL = build_mant();

  function automatic logic [GAIN_W-1:0] att_to_gain(input logic [ATT_W-1:0] code);
    logic [5:0]        r;
    logic [4:0]        k;
    logic [GAIN_W-1:0] m;
    if (code >= ATT_FLOOR) return '0;
    r = 6'(code % SEG_C);
    k = 5'(code / SEG_C);
    m = MANT_TBL[int'(r)*GAIN_W +: GAIN_W];
    return m >> k;
  endfunction

  function automatic logic [ATT_W-1:0] pick_target(input logic [ATT_W-1:0] vol,
                                                   input logic muted);
    if (muted) return ATT_FLOOR;
    if (vol > ATT_FLOOR) return ATT_FLOOR;
    return vol;
  endfunction

  function automatic logic [ATT_W-1:0] ramp_next(input logic [ATT_W-1:0] cur,
                                                 input logic [ATT_W-1:0] tgt,
                                                 input logic en);
    if (!en || cur == tgt) return cur;
    if (cur < tgt) return cur + 1'b1;
    return cur - 1'b1;
  endfunction

endpackage

// File: rtl/svc_rate_tick.sv
module svc_rate_tick
  import svc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              step_en
);

  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             count_done;

  always_comb begin
    limit = '0;
    for (int i = 0; i < CNT_W; i++) limit[i] = (i < int'(rate_sel));
  end

  assign count_done = (cnt_q >= limit);
  assign step_en    = in_valid && count_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (step_en)  cnt_q <= '0;
    else if (in_valid) cnt_q <= cnt_q + 1'b1;
  end

  AST_RATE1_EVERY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rate_sel == RATE_EVERY_1) |-> step_en); // R5

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/svc_ramp_ch.sv
module svc_ramp_ch
  import svc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [ATT_W-1:0]  vol,
  input  logic              mute,
  output logic [ATT_W-1:0]  att_q,
  output logic [GAIN_W-1:0] gain_q
);

  logic [ATT_W-1:0] tgt;
  logic [ATT_W-1:0] att_d;

  assign tgt   = pick_target(vol, mute);
  assign att_d = ramp_next(att_q, tgt, step_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q  <= ATT_FLOOR;
      gain_q <= '0;
    end else begin
      att_q  <= att_d;
      gain_q <= att_to_gain(att_q);
    end
  end

  AST_ONE_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (att_q != $past(att_q)) |-> (att_q == $past(att_q) + 1'b1 || att_q + 1'b1 == $past(att_q))); // R4

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= ATT_FLOOR); // R8

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(att_q)); // R5

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (att_q == tgt) |=> $stable(att_q)); // R4

  AST_MUTE_RAMPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && step_en && att_q != ATT_FLOOR) |=> (att_q == $past(att_q) + 1'b1)); // R6

  AST_FLOOR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (att_q == ATT_FLOOR) |=> (gain_q == '0)); // R3

endmodule

// File: rtl/svc_scale.sv
module svc_scale
  import svc_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0]        gain,
  output logic signed [DATA_W-1:0] out_q
);

  localparam int PROD_W = DATA_W + GAIN_W + 1;

  function automatic logic signed [DATA_W-1:0] scale(input logic signed [DATA_W-1:0] s,
                                                     input logic [GAIN_W-1:0] g);
    logic signed [PROD_W-1:0] p;
    p = PROD_W'(s) * PROD_W'($signed({1'b0, g}));
    return DATA_W'(p >>> GAIN_FRAC);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= '0;
    else if (in_valid) out_q <= scale(sample, gain);
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_q)); // R11

  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain == GAIN_UNITY) |=> (out_q == $past(sample))); // R3

endmodule

// File: rtl/soft_vol_ctrl.sv
module soft_vol_ctrl
  import svc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [NUM_CH*DATA_W-1:0] in_data,
  input  logic [NUM_CH*ATT_W-1:0]  vol_att,
  input  logic [NUM_CH-1:0]        mute,
  input  logic [RATE_W-1:0]        rate_sel,
  output logic                     out_valid,
  output logic [NUM_CH*DATA_W-1:0] out_data
);

  logic step_en;

  svc_rate_tick u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .rate_sel (rate_sel),
    .step_en  (step_en)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [ATT_W-1:0]  att;
    logic [GAIN_W-1:0] gain;
    logic [DATA_W-1:0] lane_out;

    svc_ramp_ch u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .vol     (vol_att[ch*ATT_W +: ATT_W]),
      .mute    (mute[ch]),
      .att_q   (att),
      .gain_q  (gain)
    );

    svc_scale #(.DATA_W(DATA_W)) u_scale (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .sample   (in_data[ch*DATA_W +: DATA_W]),
      .gain     (gain),
      .out_q    (lane_out)
    );

    assign out_data[ch*DATA_W +: DATA_W] = lane_out;

    AST_MUTED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && att == ATT_FLOOR) |=> (lane_out == '0)); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid); // R2

endmodule

// File: tb/soft_vol_ctrl_test.sv
module soft_vol_ctrl_test;

  localparam int NUM_CH = 2;
  localparam int DATA_W = 24;
  localparam int FLOOR  = 1016;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     in_valid = 1'b0;
  logic [NUM_CH*DATA_W-1:0] in_data = '0;
  logic [NUM_CH*10-1:0]     vol_att = '0;
  logic [NUM_CH-1:0]        mute = '0;
  logic [1:0]               rate_sel = 2'd0;
  logic                     out_valid;
  logic [NUM_CH*DATA_W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int cur_m [NUM_CH];
  int vol_m [NUM_CH];
  bit mute_m [NUM_CH];
  int rate_m = 0;
  int cnt_m = 0;
  int seq = 0;

  always #4 clk = ~clk;

  soft_vol_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .vol_att(vol_att), .mute(mute), .rate_sel(rate_sel),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int target_of(int ch);
    if (mute_m[ch]) return FLOOR;
    return (vol_m[ch] > FLOOR) ? FLOOR : vol_m[ch];
  endfunction

  function automatic int nominal_gain(int c);
    int r, k, m;
    if (c >= FLOOR) return 0;
    r = c % 48;
    k = c / 48;
    m = int'($floor(32768.0 * (10.0 ** (-r / 160.0))));
    return m >> k;
  endfunction

  function automatic longint scaled(longint s, longint g);
    return (s * g) >>> 15;
  endfunction

  task automatic check_eq(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic check_lane(string tag, int ch, longint s, longint got);
    int c, g;
    longint a, b, lo, hi;
    c = cur_m[ch];
    g = nominal_gain(c);
    if (c == 0) begin
      lo = s; hi = s;
    end else begin
      a = scaled(s, (g > 0) ? g - 1 : 0);
      b = scaled(s, g + 1);
      lo = (a < b) ? a : b;
      hi = (a < b) ? b : a;
      if (c >= FLOOR) begin lo = 0; hi = 0; end
    end
    checks++;
    if (got < lo || got > hi) begin
      failures++;
      $display("FAIL %s ch%0d att=%0d sample=%0d got=%0d exp=[%0d,%0d]",
               tag, ch, c, s, got, lo, hi);
    end
  endtask

  function automatic int gen_sample(int i, int ch);
    int v;
    if (ch == 0 && i % 97 == 0) return -8388608;
    v = (i * 104729 + ch * 7777 + 12345) % 8388607;
    if (v < 0) v = -v;
    return ((i + ch) % 2 == 0) ? v : -v;
  endfunction

  task automatic apply_cfg();
    for (int ch = 0; ch < NUM_CH; ch++) begin
      vol_att[ch*10 +: 10] = 10'(vol_m[ch]);
      mute[ch] = mute_m[ch];
    end
    rate_sel = 2'(rate_m);
  endtask

  task automatic send_frame(string tag);
    int s [NUM_CH];
    logic [NUM_CH*DATA_W-1:0] held;
    @(negedge clk);
    apply_cfg();
    for (int ch = 0; ch < NUM_CH; ch++) begin
      s[ch] = gen_sample(seq, ch);
      in_data[ch*DATA_W +: DATA_W] = DATA_W'(s[ch]);
    end
    in_valid = 1'b1;
    @(negedge clk);
    check_eq({tag, " R2 out_valid"}, longint'(out_valid), 1);
    for (int ch = 0; ch < NUM_CH; ch++)
      check_lane(tag, ch, s[ch], longint'($signed(out_data[ch*DATA_W +: DATA_W])));
    // model step per R4/R5
    if (cnt_m >= (1 << rate_m) - 1) begin
      cnt_m = 0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (cur_m[ch] < target_of(ch)) cur_m[ch]++;
        else if (cur_m[ch] > target_of(ch)) cur_m[ch]--;
      end
    end else begin
      cnt_m++;
    end
    in_valid = 1'b0;
    in_data  = {NUM_CH{24'h5A5A5A}} ^ NUM_CH*DATA_W'(seq);
    held     = out_data;
    seq++;
    @(negedge clk);
    check_eq("R11 idle out_valid", longint'(out_valid), 0);
    check_eq("R11 idle hold", longint'(out_data != held), 0);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) send_frame(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      cur_m[ch] = FLOOR; vol_m[ch] = 0; mute_m[ch] = 1'b0;
    end
    repeat (3) @(negedge clk);
    check_eq("R1 reset out_valid", longint'(out_valid), 0);
    check_eq("R1 reset out_data", longint'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 after reset out_data", longint'(out_data), 0);

    // fade-in from the floor over the full code range, step every sample
    run("R1 R3 R4 full sweep", 1020);

    // clamp on an oversize code, step every 4th sample
    rate_m = 2; vol_m[0] = 80; vol_m[1] = 1023;
    run("R5 R8 rate4 clamp", 4100);

    // mute one channel only, step every 2nd sample
    rate_m = 1; mute_m[0] = 1'b1;
    run("R6 R10 mute ch0", 300);
    vol_m[1] = 500;
    run("R10 ch1 down", 200);

    // unmute and retarget in the middle of ramps, step every 8th sample
    rate_m = 3; mute_m[0] = 1'b0; vol_m[1] = 900;
    run("R7 R9 rate8 retarget", 600);
    vol_m[0] = 300; vol_m[1] = 10;
    run("R9 reverse", 900);

    // back to full scale at the fastest rate
    rate_m = 0; vol_m[0] = 0; vol_m[1] = 0;
    run("R4 R5 rate1 to unity", 1100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule